// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Pool

This block is a small pool of waiting slots that sits in front of one functional unit of an out-of-order core. Each issued operation takes a free slot together with its two source operands. An operand arrives either as a value or as the tag of the producer that will later compute it. A tag of zero means the value is already present. Once issued, a slot watches a shared result broadcast bus on its own. When the bus tag matches one of the slot's pending producer tags, the slot takes the bus data for that operand. The two operands fill independently and in any order.

A slot whose operands are both present offers itself for dispatch. The lowest-indexed ready slot is sent to the functional unit, together with its own result tag, and its slot frees at the next clock edge. Issue stalls while every slot is occupied. Each slot's result tag is its index plus a fixed base, so these tags do not collide with tags from other producers.

Each slot runs a three-state machine:
- FREE goes to WAIT on allocation when an operand is still pending, or straight to READY when both are resolved.
- WAIT goes to READY in the cycle its last pending operand is captured.
- READY goes to FREE in the cycle it is granted dispatch.

Top module: `rs_pool`

## Requirements
- R1: After reset every slot is FREE: `iss_ready` is 1, `disp_valid` is 0 and `iss_tag` equals TAG_BASE.
- R2: An accepted issue (`iss_valid` and `iss_ready` both 1) fills the lowest-indexed FREE slot. `iss_tag` gives that slot's result tag, which is the slot index plus TAG_BASE.
- R3: An operand issued with tag value 0 is treated as present, and its value is later dispatched unchanged.
- R4: A waiting slot whose pending tag for an operand equals `bc_tag` while `bc_valid` is 1 captures `bc_data` into that operand and marks it present. The two operands are captured independently, in any order and in different cycles.
- R5: If an issue names a nonzero tag equal to `bc_tag` in a cycle where `bc_valid` is 1, the new slot stores `bc_data` for that operand and marks it present at once.
- R6: A slot is dispatched only when both its operands are present. `disp_valid` is then 1, and `disp_op`, `disp_a`, `disp_b` and `disp_tag` carry its operation, operand values and result tag.
- R7: At most one slot dispatches per cycle. When several slots are ready, the lowest-indexed one is chosen.
- R8: A dispatched slot is FREE at the next clock edge and can accept the next issue.
- R9: While all slots are occupied, `iss_ready` is 0 and an asserted `iss_valid` changes no slot.
- R10: A broadcast with `bc_valid` at 0, or with a tag matching no pending operand, changes no stored operand. Tag 0 is never matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code of the issued op |
| iss_tag_a | input | TAG_W | Producer tag of operand A, 0 when the value is present |
| iss_val_a | input | DATA_W | Value of operand A |
| iss_tag_b | input | TAG_W | Producer tag of operand B, 0 when the value is present |
| iss_val_b | input | DATA_W | Value of operand B |
| iss_ready | output | 1 | A slot is free, so the issue is accepted |
| iss_tag | output | TAG_W | Result tag of the slot an issue would take |
| bc_valid | input | 1 | Broadcast bus carries a result |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_data | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | A slot is dispatched this cycle |
| disp_op | output | OP_W | Operation code of the dispatched slot |
| disp_a | output | DATA_W | Operand A value of the dispatched slot |
| disp_b | output | DATA_W | Operand B value of the dispatched slot |
| disp_tag | output | TAG_W | Result tag of the dispatched slot |

## Verification
Several kinds of issue are tried:
- Fully resolved issues show that a slot becomes ready without any bus traffic.
- Issues whose operands are resolved by the bus in the order B then A, and in separate cycles, show that the operands fill independently.
- An issue that meets its producer's broadcast in the same cycle separates the bypass path from the ordinary capture path.

A pool filled with slots that wait on one shared tag, then released by a single broadcast, shows lowest-index dispatch ordering, the stall while full and slot reuse. Disabled and non-matching broadcasts confirm that nothing changes without a real match. A long randomised run over a small tag space then mixes all of these patterns.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } slot_state_e;

endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  gnt_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
            end
        end
        any_o = |req_i;
        gnt_o = '0;
        if (any_o) begin
            gnt_o[idx_o] = 1'b1;
        end
    end

    // R7: the winner has no lower-indexed competitor
    p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));

    // R7: a grant always lands on a requester
    p_grant_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~req_i) == '0);

endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [TAG_W-1:0]  tag_a_i,
    input  logic [DATA_W-1:0] val_a_i,
    input  logic [TAG_W-1:0]  tag_b_i,
    input  logic [DATA_W-1:0] val_b_i,
    input  logic              bc_valid_i,
    input  logic [TAG_W-1:0]  bc_tag_i,
    input  logic [DATA_W-1:0] bc_data_i,
    input  logic              grant_i,
    output logic              busy_o,
    output logic              ready_o,
    output logic [OP_W-1:0]   op_o,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] b_o
);

    slot_state_e       state_q, state_n;
    logic [OP_W-1:0]   op_q, op_n;
    logic [DATA_W-1:0] va_q, va_n, vb_q, vb_n;
    logic [TAG_W-1:0]  ta_q, ta_n, tb_q, tb_n;

    function automatic logic bus_hit(input logic [TAG_W-1:0] t);
        return bc_valid_i && (t != '0) && (t == bc_tag_i);
    endfunction

    // operand capture: at allocation (with bypass) or while waiting
    always_comb begin
        op_n = op_q;
        va_n = va_q;
        ta_n = ta_q;
        vb_n = vb_q;
        tb_n = tb_q;
        if (alloc_i) begin
            op_n = op_i;
            va_n = bus_hit(tag_a_i) ? bc_data_i : val_a_i;
            ta_n = bus_hit(tag_a_i) ? '0 : tag_a_i;
            vb_n = bus_hit(tag_b_i) ? bc_data_i : val_b_i;
            tb_n = bus_hit(tag_b_i) ? '0 : tag_b_i;
        end else if (state_q == ST_WAIT) begin
            if (bus_hit(ta_q)) begin
                va_n = bc_data_i;
                ta_n = '0;
            end
            if (bus_hit(tb_q)) begin
                vb_n = bc_data_i;
                tb_n = '0;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_FREE: begin
                if (alloc_i) begin
                    state_n = (ta_n == '0 && tb_n == '0) ? ST_READY : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (ta_n == '0 && tb_n == '0) begin
                    state_n = ST_READY;
                end
            end
            ST_READY: begin
                if (grant_i) begin
                    state_n = ST_FREE;
                end
            end
            default: state_n = ST_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
        end else begin
            state_q <= state_n;
        end
    end

    // operand storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0;
            va_q <= '0;
            ta_q <= '0;
            vb_q <= '0;
            tb_q <= '0;
        end else begin
            op_q <= op_n;
            va_q <= va_n;
            ta_q <= ta_n;
            vb_q <= vb_n;
            tb_q <= tb_n;
        end
    end

    // outputs
    always_comb begin
        busy_o  = (state_q != ST_FREE);
        ready_o = (state_q == ST_READY);
        op_o    = op_q;
        a_o     = va_q;
        b_o     = vb_q;
    end

    // R6: grant only reaches a slot whose operands are both present
    p_grant_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |-> (state_q == ST_READY && ta_q == '0 && tb_q == '0));

    // R9: allocation only targets a free slot
    p_alloc_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> (state_q == ST_FREE));

    // R4: a matching broadcast fills operand A
    p_capture_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && bc_valid_i && ta_q != '0 && bc_tag_i == ta_q)
        |=> (ta_q == '0 && va_q == $past(bc_data_i)));

    // R4: a matching broadcast fills operand B
    p_capture_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && bc_valid_i && tb_q != '0 && bc_tag_i == tb_q)
        |=> (tb_q == '0 && vb_q == $past(bc_data_i)));

    // R10: without a match a waiting operand is left alone
    p_hold_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !(bc_valid_i && bc_tag_i == ta_q))
        |=> ($stable(ta_q) && $stable(va_q)));

    // R5: bypass at allocation
    p_bypass_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && bc_valid_i && tag_a_i != '0 && bc_tag_i == tag_a_i)
        |=> (ta_q == '0 && va_q == $past(bc_data_i)));

    // R8: a granted slot is free at the next edge
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |=> (state_q == ST_FREE));

endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
    parameter int OP_W     = 4,
    parameter int DATA_W   = 16,
    parameter int TAG_W    = 4,
    parameter int NUM_SLOT = 4,
    parameter int TAG_BASE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_tag_a,
    input  logic [DATA_W-1:0] iss_val_a,
    input  logic [TAG_W-1:0]  iss_tag_b,
    input  logic [DATA_W-1:0] iss_val_b,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              disp_valid,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    output logic [TAG_W-1:0]  disp_tag
);

    localparam int IW = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1;

    logic [NUM_SLOT-1:0] busy_vec, ready_vec;
    logic [NUM_SLOT-1:0] free_gnt, disp_gnt, alloc_vec;
    logic [IW-1:0]       free_idx, disp_idx;
    logic                free_any, disp_any;
    logic [OP_W-1:0]     op_arr [NUM_SLOT];
    logic [DATA_W-1:0]   a_arr  [NUM_SLOT];
    logic [DATA_W-1:0]   b_arr  [NUM_SLOT];

    rs_pick #(.N(NUM_SLOT)) u_free_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (~busy_vec),
        .gnt_o (free_gnt),
        .idx_o (free_idx),
        .any_o (free_any)
    );

    rs_pick #(.N(NUM_SLOT)) u_disp_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (ready_vec),
        .gnt_o (disp_gnt),
        .idx_o (disp_idx),
        .any_o (disp_any)
    );

    assign alloc_vec = iss_valid ? free_gnt : '0;

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
        rs_slot #(
            .OP_W   (OP_W),
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (alloc_vec[g]),
            .op_i       (iss_op),
            .tag_a_i    (iss_tag_a),
            .val_a_i    (iss_val_a),
            .tag_b_i    (iss_tag_b),
            .val_b_i    (iss_val_b),
            .bc_valid_i (bc_valid),
            .bc_tag_i   (bc_tag),
            .bc_data_i  (bc_data),
            .grant_i    (disp_gnt[g]),
            .busy_o     (busy_vec[g]),
            .ready_o    (ready_vec[g]),
            .op_o       (op_arr[g]),
            .a_o        (a_arr[g]),
            .b_o        (b_arr[g])
        );
    end

    always_comb begin
        iss_ready  = free_any;
        iss_tag    = TAG_W'(free_idx) + TAG_W'(TAG_BASE);
        disp_valid = disp_any;
        disp_op    = op_arr[disp_idx];
        disp_a     = a_arr[disp_idx];
        disp_b     = b_arr[disp_idx];
        disp_tag   = TAG_W'(disp_idx) + TAG_W'(TAG_BASE);
    end

    // R7: at most one dispatch per cycle
    p_one_dispatch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(disp_gnt));

    // R9: a full pool refuses issue
    p_full_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy_vec) |-> !iss_ready);

    // R9: a refused issue never raises occupancy
    p_no_grow_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready)
        |=> ($countones(busy_vec) <= $past($countones(busy_vec))));

    // R2: an accepted issue occupies one more slot unless one dispatches
    p_issue_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && !disp_valid)
        |=> ($countones(busy_vec) == $past($countones(busy_vec)) + 1));

endmodule

// File: tb/rs_pool_tb.sv
`timescale 1ns/1ps
module rs_pool_tb;

    localparam int OP_W = 4, DW = 16, TW = 4, N = 4, BASE = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [OP_W-1:0] iss_op = '0;
    logic [TW-1:0] iss_tag_a = '0, iss_tag_b = '0;
    logic [DW-1:0] iss_val_a = '0, iss_val_b = '0;
    logic          iss_ready;
    logic [TW-1:0] iss_tag;
    logic          bc_valid = 1'b0;
    logic [TW-1:0] bc_tag = '0;
    logic [DW-1:0] bc_data = '0;
    logic          disp_valid;
    logic [OP_W-1:0] disp_op;
    logic [DW-1:0] disp_a, disp_b;
    logic [TW-1:0] disp_tag;

    int vectors = 0, miscompares = 0;
    bit done = 0;
    string phase = "";

    int m_busy[N], m_op[N], m_va[N], m_ta[N], m_vb[N], m_tb[N];

    always #2 clk = ~clk;

    rs_pool #(.OP_W(OP_W), .DATA_W(DW), .TAG_W(TW), .NUM_SLOT(N), .TAG_BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_tag_a(iss_tag_a), .iss_val_a(iss_val_a),
        .iss_tag_b(iss_tag_b), .iss_val_b(iss_val_b),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_a(disp_a), .disp_b(disp_b), .disp_tag(disp_tag)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, phase, act, exp, $time);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < N; i++) if (m_busy[i] == 0) return i;
        return -1;
    endfunction

    function automatic int lowest_ready();
        for (int i = 0; i < N; i++)
            if (m_busy[i] != 0 && m_ta[i] == 0 && m_tb[i] == 0) return i;
        return -1;
    endfunction

    task automatic compare();
        int f = lowest_free();
        int r = lowest_ready();
        check("R9 iss_ready", int'(iss_ready), (f >= 0) ? 1 : 0);
        if (f >= 0) check("R2 iss_tag", int'(iss_tag), f + BASE);
        check("R6 disp_valid", int'(disp_valid), (r >= 0) ? 1 : 0);
        if (r >= 0) begin
            check("R7 disp_tag", int'(disp_tag), r + BASE);
            check("R6 disp_op", int'(disp_op), m_op[r]);
            check("R4 disp_a", int'(disp_a), m_va[r]);
            check("R4 disp_b", int'(disp_b), m_vb[r]);
        end
    endtask

    task automatic model_step();
        int f = lowest_free();
        int r = lowest_ready();
        int bt = int'(bc_tag);
        for (int i = 0; i < N; i++) begin
            if (m_busy[i] != 0) begin
                if (bc_valid && m_ta[i] != 0 && m_ta[i] == bt) begin m_va[i] = int'(bc_data); m_ta[i] = 0; end
                if (bc_valid && m_tb[i] != 0 && m_tb[i] == bt) begin m_vb[i] = int'(bc_data); m_tb[i] = 0; end
            end
        end
        if (r >= 0) m_busy[r] = 0;
        if (iss_valid && f >= 0) begin
            m_busy[f] = 1;
            m_op[f] = int'(iss_op);
            m_ta[f] = int'(iss_tag_a); m_va[f] = int'(iss_val_a);
            m_tb[f] = int'(iss_tag_b); m_vb[f] = int'(iss_val_b);
            if (bc_valid && m_ta[f] != 0 && m_ta[f] == bt) begin m_va[f] = int'(bc_data); m_ta[f] = 0; end
            if (bc_valid && m_tb[f] != 0 && m_tb[f] == bt) begin m_vb[f] = int'(bc_data); m_tb[f] = 0; end
        end
    endtask

    task automatic cyc(input bit iv, input int op, input int ta, input int va,
                       input int tb, input int vb, input bit bv, input int bt, input int bd);
        @(negedge clk);
        iss_valid = iv; iss_op = OP_W'(op);
        iss_tag_a = TW'(ta); iss_val_a = DW'(va);
        iss_tag_b = TW'(tb); iss_val_b = DW'(vb);
        bc_valid = bv; bc_tag = TW'(bt); bc_data = DW'(bd);
        #1;
        compare();
        model_step();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_busy[i] = 0; m_op[i] = 0; m_va[i] = 0; m_ta[i] = 0; m_vb[i] = 0; m_tb[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        phase = "R1 reset";
        check("R1 iss_ready", int'(iss_ready), 1);
        check("R1 disp_valid", int'(disp_valid), 0);
        check("R1 iss_tag", int'(iss_tag), BASE);
        rst_n = 1'b1;

        // R3, R7: resolved issues back to back
        phase = "R3 resolved";
        cyc(1, 3, 0, 100, 0, 200, 0, 0, 0);
        cyc(1, 4, 0, 101, 0, 201, 0, 0, 0);
        cyc(1, 5, 0, 102, 0, 202, 0, 0, 0);
        idle(4);

        // R4: B then A in separate cycles
        phase = "R4 split capture";
        cyc(1, 6, 9, 0, 10, 0, 0, 0, 0);
        idle(1);
        cyc(0, 0, 0, 0, 0, 0, 1, 10, 777);
        idle(1);
        cyc(0, 0, 0, 0, 0, 0, 1, 9, 555);
        idle(3);

        // R5: bypass at issue
        phase = "R5 bypass";
        cyc(1, 7, 11, 0, 11, 0, 1, 11, 4242);
        idle(3);

        // R10: disabled bus and non-matching tags leave operands alone
        phase = "R10 ignored bus";
        cyc(1, 8, 13, 1, 0, 2, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 13, 999);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 998);
        cyc(0, 0, 0, 0, 0, 0, 1, 14, 997);
        idle(1);
        cyc(0, 0, 0, 0, 0, 0, 1, 13, 321);
        idle(3);

        // R9, R8, R7: fill, stall, release together, reuse
        phase = "R9 full stall";
        for (int i = 0; i < N; i++) cyc(1, i + 1, 12, i, 0, i + 50, 0, 0, 0);
        cyc(1, 15, 0, 9, 0, 9, 0, 0, 0);
        cyc(1, 15, 0, 9, 0, 9, 0, 0, 0);
        phase = "R8 reuse";
        cyc(0, 0, 0, 0, 0, 0, 1, 12, 31000);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc(1, 9, 0, 11, 0, 22, 0, 0, 0);
        idle(6);

        // randomised mix
        phase = "random";
        for (int k = 0; k < 3000; k++) begin
            cyc($urandom_range(0, 1), $urandom_range(0, 15),
                ($urandom_range(0, 1) != 0) ? 0 : $urandom_range(1, 12), $urandom_range(0, 65535),
                ($urandom_range(0, 1) != 0) ? 0 : $urandom_range(1, 12), $urandom_range(0, 65535),
                $urandom_range(0, 1), $urandom_range(0, 12), $urandom_range(0, 65535));
        end
        phase = "drain";
        for (int t = 1; t <= 12; t++) cyc(0, 0, 0, 0, 0, 0, 1, t, t * 7);
        idle(6);
        finish_run();
    end

endmodule